// File: doc/BRIEF.md
# IOMMU Context Control and Fault Register Bank

This block is the memory-mapped register bank of a small address-translation unit that serves several translation contexts. Each context has its own group of 32-bit registers at a fixed stride of 0x40 bytes. The groups hold:

- a control word, with translation enable, interrupt enable, a self-clearing TLB flush request and a few mode bits;
- a translation-table control word;
- two 64-bit table base addresses, each split into low and high words;
- two memory-attribute words;
- a fault status word;
- a read-only error address.

A stub translation engine reports faults on a set of fault inputs. The first fault that reaches a context with no pending error latches the fault flags, the error code, the error level and the faulting input address. Every context with interrupts enabled and an error pending drives a single shared interrupt. Software clears a fault by writing zero to the status word. It can only flush the whole TLB of a context: it writes the flush bit and then polls it until it drops. In this model the invalidation always takes a fixed number of cycles.

The host side is a plain register bus. A write takes effect at the clock edge where `hostWrEn` is high. A read returns its data on `hostRdData` in the cycle after the edge where `hostRdEn` was high.

Top module: `iommu_ctx_regs`

## Requirements
- R1: The registers of context c sit at byte address c×0x40 plus the register offset (context index in hostAddr[8:6], offset in hostAddr[5:0]). A context index at or above NUM_CTX is unmapped.
- R2: The table control word (0x08), the table base words (0x10, 0x14, 0x18, 0x1C) and the attribute words (0x28, 0x2C) store and return all 32 written bits.
- R3: Control word (0x00) bits 0 (translation enable), 2 (interrupt enable), 3 (walk enable), 5:4 (route select), 16 and 17 are writable. All other bits except bit 1 read as 0.
- R4: Writing 1 to control bit 1 while no flush is pending makes bit 1 read 1 for exactly FLUSH_CYCLES (default 4) cycles after the write edge, then 0. Writing 1 again while the flush is pending does not restart it.
- R5: Writing 0 to control bit 1 while a flush is pending leaves the flush running. The other control bits still update.
- R6: A fault report sets the status word (0x20) as follows: bit 0 translation fault, bit 1 page fault, bit 2 walk abort, bit 4 multiple hit (faultFlags bits 0..3 in that order), bits 10:8 the error code, bits 13:12 the error level. The faulting address is latched into the error address word (0x24).
- R7: Writing exactly zero to the status word clears the flags, the code and the level. Writing any nonzero value has no effect.
- R8: The error address keeps its value through a status clear only if it was read after the fault was captured. Otherwise the clear sets it to 0.
- R9: A fault that arrives at a context with any flag already set is dropped, and the status and address of the first fault are kept. A fault whose flags are all zero is ignored.
- R10: `irq` is high exactly when some context has interrupt enable set and at least one error flag set.
- R11: Reads of unmapped offsets (including misaligned ones) return 0, and writes to them are ignored. `hostRdData` is 0 in cycles that follow no read.
- R12: After reset every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Register write strobe |
| hostRdEn | input | 1 | Register read strobe |
| hostAddr | input | 9 | Byte address: context index and register offset |
| hostWrData | input | 32 | Write data |
| hostRdData | output | 32 | Read data, valid the cycle after the read strobe |
| faultValid | input | 1 | Fault report from the translation engine |
| faultCtx | input | 3 | Context of the reported fault |
| faultFlags | input | 4 | Translation, page, abort and multiple-hit flags |
| faultCode | input | 3 | Error code |
| faultLevel | input | 2 | Table level of the error |
| faultAddr | input | IN_ADDR_W | Faulting input address |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that all inputs are known after reset and that the fault fields matter only while `faultValid` is high. The check that a dropped fault leaves the address stable assumes no status write to that same context in that cycle. The stimulus never combines the two on one context. It also drives host strobes and fault reports one at a time, away from the clock edge, so that every read can be predicted from the requirements alone.

// File: rtl/iommu_ctx_pkg.sv
package iommu_ctx_pkg;
  localparam int CTX_IDX_W   = 3;
  localparam int OFS_W       = 6;
  localparam int HOST_ADDR_W = CTX_IDX_W + OFS_W;
  localparam int DATA_W      = 32;
  localparam int FLAG_W      = 4;
  localparam int CODE_W      = 3;
  localparam int LEVEL_W     = 2;

  localparam logic [OFS_W-1:0] OFS_CTRL    = 6'h00;
  localparam logic [OFS_W-1:0] OFS_TBLCTL  = 6'h08;
  localparam logic [OFS_W-1:0] OFS_BASE0LO = 6'h10;
  localparam logic [OFS_W-1:0] OFS_BASE0HI = 6'h14;
  localparam logic [OFS_W-1:0] OFS_BASE1LO = 6'h18;
  localparam logic [OFS_W-1:0] OFS_BASE1HI = 6'h1C;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 6'h20;
  localparam logic [OFS_W-1:0] OFS_ERRADDR = 6'h24;
  localparam logic [OFS_W-1:0] OFS_ATTR0   = 6'h28;
  localparam logic [OFS_W-1:0] OFS_ATTR1   = 6'h2C;

  localparam int CTRL_FLUSH = 1;
  localparam int CTRL_INTEN = 2;
  // enable, interrupt enable, walk enable, route select, bits 16 and 17
  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h0003_003D;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_TBLCTL, SEL_BASE0LO, SEL_BASE0HI,
    SEL_BASE1LO, SEL_BASE1HI, SEL_STATUS, SEL_ERRADDR, SEL_ATTR0, SEL_ATTR1
  } regSel_e;

  typedef struct packed {
    logic                 wr;
    logic                 rd;
    regSel_e              sel;
    logic [CTX_IDX_W-1:0] ctx;
    logic                 faultTake;
    logic [CTX_IDX_W-1:0] faultCtx;
  } strobes_t;

  function automatic logic [DATA_W-1:0] packStatus(
      input logic [FLAG_W-1:0] flags, input logic [CODE_W-1:0] code,
      input logic [LEVEL_W-1:0] level);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[0]     = flags[0];
    w[1]     = flags[1];
    w[2]     = flags[2];
    w[4]     = flags[3];
    w[10:8]  = code;
    w[13:12] = level;
    return w;
  endfunction
endpackage

// File: rtl/iommu_ctx_decode.sv
module iommu_ctx_decode import iommu_ctx_pkg::*; #(
  parameter int NUM_CTX = 8
) (
  input  logic                   hostWrEn,
  input  logic                   hostRdEn,
  input  logic [HOST_ADDR_W-1:0] hostAddr,
  input  logic                   faultValid,
  input  logic [CTX_IDX_W-1:0]   faultCtx,
  input  logic [FLAG_W-1:0]      faultFlags,
  output strobes_t               stb
);
  logic [CTX_IDX_W-1:0] ctxIdx;
  logic [OFS_W-1:0]     ofs;
  regSel_e              sel;

  always_comb begin
    ctxIdx = hostAddr[HOST_ADDR_W-1:OFS_W];
    ofs    = hostAddr[OFS_W-1:0];
    sel    = SEL_NONE;
    if (int'(ctxIdx) < NUM_CTX) begin
      case (ofs)
        OFS_CTRL:    sel = SEL_CTRL;
        OFS_TBLCTL:  sel = SEL_TBLCTL;
        OFS_BASE0LO: sel = SEL_BASE0LO;
        OFS_BASE0HI: sel = SEL_BASE0HI;
        OFS_BASE1LO: sel = SEL_BASE1LO;
        OFS_BASE1HI: sel = SEL_BASE1HI;
        OFS_STATUS:  sel = SEL_STATUS;
        OFS_ERRADDR: sel = SEL_ERRADDR;
        OFS_ATTR0:   sel = SEL_ATTR0;
        OFS_ATTR1:   sel = SEL_ATTR1;
        default:     sel = SEL_NONE;
      endcase
    end
    stb.sel       = sel;
    stb.ctx       = ctxIdx;
    stb.wr        = hostWrEn && (sel != SEL_NONE);
    stb.rd        = hostRdEn && (sel != SEL_NONE);
    stb.faultTake = faultValid && (int'(faultCtx) < NUM_CTX) && (|faultFlags);
    stb.faultCtx  = faultCtx;
  end
endmodule

// File: rtl/iommu_ctx_datapath.sv
module iommu_ctx_datapath import iommu_ctx_pkg::*; #(
  parameter int NUM_CTX      = 8,
  parameter int IN_ADDR_W    = 32,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobes_t                            stb,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [FLAG_W-1:0]                   faultFlags,
  input  logic [CODE_W-1:0]                   faultCode,
  input  logic [LEVEL_W-1:0]                  faultLevel,
  input  logic [IN_ADDR_W-1:0]                faultAddr,
  output logic [DATA_W-1:0]                   rdData,
  output logic                                irq,
  output logic [NUM_CTX-1:0]                  ctxBusy,
  output logic [NUM_CTX-1:0]                  ctxFault,
  output logic [NUM_CTX-1:0]                  ctxIntEn,
  output logic [NUM_CTX-1:0][IN_ADDR_W-1:0]   ctxErrAddr
);
  localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);

  logic [NUM_CTX-1:0][DATA_W-1:0] ctxWord;
  logic [DATA_W-1:0]              rdNext;

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
    logic [DATA_W-1:0]    ctrlQ, tblQ, base0LoQ, base0HiQ, base1LoQ, base1HiQ;
    logic [DATA_W-1:0]    attr0Q, attr1Q, word;
    logic                 busyQ, seenQ;
    logic [CNT_W-1:0]     cntQ;
    logic [FLAG_W-1:0]    flagQ;
    logic [CODE_W-1:0]    codeQ;
    logic [LEVEL_W-1:0]   levelQ;
    logic [IN_ADDR_W-1:0] errAddrQ;
    logic                 wrHere, rdHere, faultHere, clrHere;

    assign wrHere    = stb.wr && (stb.ctx == CTX_IDX_W'(i));
    assign rdHere    = stb.rd && (stb.ctx == CTX_IDX_W'(i));
    assign faultHere = stb.faultTake && (stb.faultCtx == CTX_IDX_W'(i));
    assign clrHere   = wrHere && (stb.sel == SEL_STATUS) && (wrData == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlQ    <= '0;
        tblQ     <= '0;
        base0LoQ <= '0;
        base0HiQ <= '0;
        base1LoQ <= '0;
        base1HiQ <= '0;
        attr0Q   <= '0;
        attr1Q   <= '0;
        busyQ    <= 1'b0;
        cntQ     <= '0;
        flagQ    <= '0;
        codeQ    <= '0;
        levelQ   <= '0;
        errAddrQ <= '0;
        seenQ    <= 1'b0;
      end else begin
        // modelled invalidation countdown
        if (busyQ) begin
          if (cntQ == '0) busyQ <= 1'b0;
          else            cntQ  <= cntQ - 1'b1;
        end
        if (wrHere) begin
          case (stb.sel)
            SEL_CTRL: begin
              ctrlQ <= wrData & CTRL_WMASK;
              if (wrData[CTRL_FLUSH] && !busyQ) begin
                busyQ <= 1'b1;
                cntQ  <= CNT_W'(FLUSH_CYCLES - 1);
              end
            end
            SEL_TBLCTL:  tblQ     <= wrData;
            SEL_BASE0LO: base0LoQ <= wrData;
            SEL_BASE0HI: base0HiQ <= wrData;
            SEL_BASE1LO: base1LoQ <= wrData;
            SEL_BASE1HI: base1HiQ <= wrData;
            SEL_ATTR0:   attr0Q   <= wrData;
            SEL_ATTR1:   attr1Q   <= wrData;
            default: ;
          endcase
        end
        if (rdHere && (stb.sel == SEL_ERRADDR)) seenQ <= 1'b1;
        if (clrHere) begin
          flagQ  <= '0;
          codeQ  <= '0;
          levelQ <= '0;
          if (!seenQ) errAddrQ <= '0;
        end
        if (faultHere && (flagQ == '0)) begin
          flagQ    <= faultFlags;
          codeQ    <= faultCode;
          levelQ   <= faultLevel;
          errAddrQ <= faultAddr;
          seenQ    <= 1'b0;
        end
      end
    end

    always_comb begin
      case (stb.sel)
        SEL_CTRL:    word = {ctrlQ[DATA_W-1:2], busyQ, ctrlQ[0]};
        SEL_TBLCTL:  word = tblQ;
        SEL_BASE0LO: word = base0LoQ;
        SEL_BASE0HI: word = base0HiQ;
        SEL_BASE1LO: word = base1LoQ;
        SEL_BASE1HI: word = base1HiQ;
        SEL_STATUS:  word = packStatus(flagQ, codeQ, levelQ);
        SEL_ERRADDR: word = DATA_W'(errAddrQ);
        SEL_ATTR0:   word = attr0Q;
        SEL_ATTR1:   word = attr1Q;
        default:     word = '0;
      endcase
    end

    assign ctxWord[i]    = word;
    assign ctxBusy[i]    = busyQ;
    assign ctxFault[i]   = |flagQ;
    assign ctxIntEn[i]   = ctrlQ[CTRL_INTEN];
    assign ctxErrAddr[i] = errAddrQ;
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (stb.rd && (stb.ctx == CTX_IDX_W'(i))) rdNext = ctxWord[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  assign irq = |(ctxIntEn & ctxFault);
endmodule

// File: rtl/iommu_ctx_regs.sv
module iommu_ctx_regs import iommu_ctx_pkg::*; #(
  parameter int NUM_CTX      = 8,
  parameter int IN_ADDR_W    = 32,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostWrEn,
  input  logic                   hostRdEn,
  input  logic [HOST_ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0]      hostWrData,
  output logic [DATA_W-1:0]      hostRdData,
  input  logic                   faultValid,
  input  logic [CTX_IDX_W-1:0]   faultCtx,
  input  logic [FLAG_W-1:0]      faultFlags,
  input  logic [CODE_W-1:0]      faultCode,
  input  logic [LEVEL_W-1:0]     faultLevel,
  input  logic [IN_ADDR_W-1:0]   faultAddr,
  output logic                   irq
);
  strobes_t                         stb;
  logic [NUM_CTX-1:0]               ctxBusy, ctxFault, ctxIntEn;
  logic [NUM_CTX-1:0][IN_ADDR_W-1:0] ctxErrAddr;

  iommu_ctx_decode #(.NUM_CTX(NUM_CTX)) u_decode (
    .hostWrEn  (hostWrEn),
    .hostRdEn  (hostRdEn),
    .hostAddr  (hostAddr),
    .faultValid(faultValid),
    .faultCtx  (faultCtx),
    .faultFlags(faultFlags),
    .stb       (stb)
  );

  iommu_ctx_datapath #(
    .NUM_CTX(NUM_CTX), .IN_ADDR_W(IN_ADDR_W), .FLUSH_CYCLES(FLUSH_CYCLES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (hostWrData),
    .faultFlags(faultFlags),
    .faultCode (faultCode),
    .faultLevel(faultLevel),
    .faultAddr (faultAddr),
    .rdData    (hostRdData),
    .irq       (irq),
    .ctxBusy   (ctxBusy),
    .ctxFault  (ctxFault),
    .ctxIntEn  (ctxIntEn),
    .ctxErrAddr(ctxErrAddr)
  );
endmodule

// File: rtl/iommu_ctx_regs_chk.sv
module iommu_ctx_regs_chk import iommu_ctx_pkg::*; #(
  parameter int NUM_CTX      = 8,
  parameter int IN_ADDR_W    = 32,
  parameter int FLUSH_CYCLES = 4
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              hostWrEn,
  input logic                              hostRdEn,
  input logic [HOST_ADDR_W-1:0]            hostAddr,
  input logic [DATA_W-1:0]                 hostWrData,
  input logic [DATA_W-1:0]                 hostRdData,
  input logic                              faultValid,
  input logic [CTX_IDX_W-1:0]              faultCtx,
  input logic                              irq,
  input logic [NUM_CTX-1:0]                ctxBusy,
  input logic [NUM_CTX-1:0]                ctxFault,
  input logic [NUM_CTX-1:0][IN_ADDR_W-1:0] ctxErrAddr
);
  logic [CTX_IDX_W-1:0] aCtx;
  logic [OFS_W-1:0]     aOfs;
  logic                 mapped;

  assign aCtx = hostAddr[HOST_ADDR_W-1:OFS_W];
  assign aOfs = hostAddr[OFS_W-1:0];
  assign mapped = (int'(aCtx) < NUM_CTX) &&
                  (aOfs inside {OFS_CTRL, OFS_TBLCTL, OFS_BASE0LO, OFS_BASE0HI,
                                OFS_BASE1LO, OFS_BASE1HI, OFS_STATUS, OFS_ERRADDR,
                                OFS_ATTR0, OFS_ATTR1});

  // R11
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRdEn && !mapped |=> hostRdData == '0);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(faultValid) || $past(hostWrEn));

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_chk
    int  runLen;
    logic wrHit;
    assign wrHit = hostWrEn && (aCtx == CTX_IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN)           runLen <= 0;
      else if (ctxBusy[i]) runLen <= runLen + 1;
      else                 runLen <= 0;
    end

    // R4
    flush_start_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrHit && (aOfs == OFS_CTRL) && hostWrData[CTRL_FLUSH] && !ctxBusy[i]
      |=> ctxBusy[i]);

    // R4
    flush_length_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ctxBusy[i]) |-> runLen == FLUSH_CYCLES);

    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrHit && (aOfs == OFS_STATUS) && (hostWrData == '0) &&
      !(faultValid && (faultCtx == CTX_IDX_W'(i)))
      |=> !ctxFault[i]);

    // R9
    fault_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      ctxFault[i] && faultValid && (faultCtx == CTX_IDX_W'(i)) &&
      !(wrHit && (aOfs == OFS_STATUS))
      |=> $stable(ctxErrAddr[i]));
  end
endmodule

bind iommu_ctx_regs iommu_ctx_regs_chk #(
  .NUM_CTX(NUM_CTX), .IN_ADDR_W(IN_ADDR_W), .FLUSH_CYCLES(FLUSH_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostWrEn  (hostWrEn),
  .hostRdEn  (hostRdEn),
  .hostAddr  (hostAddr),
  .hostWrData(hostWrData),
  .hostRdData(hostRdData),
  .faultValid(faultValid),
  .faultCtx  (faultCtx),
  .irq       (irq),
  .ctxBusy   (ctxBusy),
  .ctxFault  (ctxFault),
  .ctxErrAddr(ctxErrAddr)
);

// File: tb/iommu_ctx_regs_bench.sv
`timescale 1ns/100ps
module iommu_ctx_regs_bench;
  import iommu_ctx_pkg::*;

  localparam int NCTX = 6;
  localparam int IAW  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [HOST_ADDR_W-1:0] hostAddr = '0;
  logic [DATA_W-1:0] hostWrData = '0;
  logic [DATA_W-1:0] hostRdData;
  logic faultValid = 1'b0;
  logic [CTX_IDX_W-1:0] faultCtx = '0;
  logic [FLAG_W-1:0] faultFlags = '0;
  logic [CODE_W-1:0] faultCode = '0;
  logic [LEVEL_W-1:0] faultLevel = '0;
  logic [IAW-1:0] faultAddr = '0;
  logic irq;

  int tests = 0;
  int fails = 0;
  logic [DATA_W-1:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  iommu_ctx_regs #(.NUM_CTX(NCTX), .IN_ADDR_W(IAW), .FLUSH_CYCLES(4)) u_iommu_ctx_regs (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .faultValid(faultValid), .faultCtx(faultCtx), .faultFlags(faultFlags),
    .faultCode(faultCode), .faultLevel(faultLevel), .faultAddr(faultAddr),
    .irq(irq)
  );

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                       input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [HOST_ADDR_W-1:0] mkAddr(input int ctx, input int ofs);
    return HOST_ADDR_W'(ctx * 64 + ofs);
  endfunction

  task automatic wrReg(input int ctx, input int ofs, input logic [DATA_W-1:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = mkAddr(ctx, ofs); hostWrData = d;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic rdReg(input int ctx, input int ofs, input logic [DATA_W-1:0] exp,
                       input string tag);
    @(negedge clk);
    hostRdEn = 1'b1; hostAddr = mkAddr(ctx, ofs);
    expQ.push_back(exp); tagQ.push_back(tag);
    @(posedge clk); #1;
    hostRdEn = 1'b0;
  endtask

  task automatic inject(input int ctx, input logic [3:0] fl, input logic [2:0] code,
                        input logic [1:0] lvl, input logic [IAW-1:0] a);
    @(negedge clk);
    faultValid = 1'b1; faultCtx = CTX_IDX_W'(ctx); faultFlags = fl;
    faultCode = code; faultLevel = lvl; faultAddr = a;
    @(posedge clk); #1;
    faultValid = 1'b0;
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    @(negedge clk);
    check({31'b0, irq}, {31'b0, exp}, tag);
  endtask

  // monitor: pops the expected item for every read the design answers
  always @(posedge clk) begin
    if (hostRdEn) begin
      #1;
      if (expQ.size() == 0) check(hostRdData, '0, "scoreboard underflow");
      else check(hostRdData, expQ.pop_front(), tagQ.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R12 reset state
    rdReg(0, 'h00, 32'h0, "R12 ctrl after reset");
    rdReg(5, 'h20, 32'h0, "R12 status after reset");
    rdReg(3, 'h1C, 32'h0, "R12 base hi after reset");
    rdReg(2, 'h24, 32'h0, "R12 error address after reset");
    chkIrq(1'b0, "R12 irq after reset");

    // R1 / R2 storage and stride
    wrReg(2, 'h10, 32'hA5A5_0001);
    wrReg(5, 'h10, 32'h5A5A_0002);
    wrReg(2, 'h08, 32'h8000_0123);
    wrReg(4, 'h2C, 32'h0044_FF04);
    wrReg(1, 'h1C, 32'h0000_00AB);
    wrReg(0, 'h28, 32'hFFFF_FFFF);
    rdReg(2, 'h10, 32'hA5A5_0001, "R1 ctx2 base0 low");
    rdReg(5, 'h10, 32'h5A5A_0002, "R1 ctx5 base0 low");
    rdReg(3, 'h10, 32'h0, "R1 untouched ctx3 base0 low");
    rdReg(2, 'h08, 32'h8000_0123, "R2 table control");
    rdReg(4, 'h2C, 32'h0044_FF04, "R2 attribute 1");
    rdReg(1, 'h1C, 32'h0000_00AB, "R2 base1 high");
    rdReg(0, 'h28, 32'hFFFF_FFFF, "R2 attribute 0");

    // R1 context beyond NUM_CTX, R11 unmapped offsets
    wrReg(7, 'h10, 32'h1111_1111);
    rdReg(7, 'h10, 32'h0, "R1 out-of-range context");
    rdReg(1, 'h10, 32'h0, "R1 no alias from out-of-range write");
    wrReg(0, 'h04, 32'hFFFF_FFFF);
    rdReg(0, 'h04, 32'h0, "R11 unmapped 0x04");
    rdReg(0, 'h30, 32'h0, "R11 unmapped 0x30");
    rdReg(2, 'h12, 32'h0, "R11 misaligned offset");

    // R3 control masking
    wrReg(1, 'h00, 32'hFFFF_FFFD);
    rdReg(1, 'h00, 32'h0003_003D, "R3 control writable bits");
    wrReg(1, 'h00, 32'h0);
    rdReg(1, 'h00, 32'h0, "R3 control cleared");

    // R4 flush timing
    wrReg(1, 'h00, 32'h2);
    for (int k = 0; k < 4; k++) rdReg(1, 'h00, 32'h2, "R4 flush pending");
    rdReg(1, 'h00, 32'h0, "R4 flush done");

    // R4 no restart
    wrReg(1, 'h00, 32'h2);
    wrReg(1, 'h00, 32'h2);
    for (int k = 0; k < 3; k++) rdReg(1, 'h00, 32'h2, "R4 pending no restart");
    rdReg(1, 'h00, 32'h0, "R4 done without restart");

    // R5 writing zero to flush while busy
    wrReg(1, 'h00, 32'h3);
    wrReg(1, 'h00, 32'h1);
    for (int k = 0; k < 3; k++) rdReg(1, 'h00, 32'h3, "R5 flush still pending");
    rdReg(1, 'h00, 32'h1, "R5 other bits updated");
    wrReg(1, 'h00, 32'h0);

    // R6 capture
    inject(3, 4'b0001, 3'd4, 2'd2, 32'hDEAD_BEE0);
    rdReg(3, 'h20, 32'h0000_2401, "R6 status layout");
    chkIrq(1'b0, "R10 irq off without enable");
    wrReg(3, 'h00, 32'h4);
    chkIrq(1'b1, "R10 irq with enable");

    // R9 drop while pending
    inject(3, 4'b0010, 3'd5, 2'd1, 32'h0BAD_0000);
    rdReg(3, 'h20, 32'h0000_2401, "R9 status kept");
    rdReg(3, 'h24, 32'hDEAD_BEE0, "R9 address kept");

    // R7 clear by zero only
    wrReg(3, 'h20, 32'h1);
    rdReg(3, 'h20, 32'h0000_2401, "R7 nonzero write ignored");
    chkIrq(1'b1, "R7 irq after nonzero write");
    wrReg(3, 'h20, 32'h0);
    rdReg(3, 'h20, 32'h0, "R7 zero clears");
    chkIrq(1'b0, "R10 irq after clear");
    rdReg(3, 'h24, 32'hDEAD_BEE0, "R8 address read before clear kept");

    // R8 address lost when not read
    inject(5, 4'b1000, 3'd1, 2'd1, 32'h1234_5670);
    rdReg(5, 'h20, 32'h0000_1110, "R6 multiple-hit status");
    wrReg(5, 'h20, 32'h0);
    rdReg(5, 'h24, 32'h0, "R8 unread address lost");

    // R10 OR across contexts
    wrReg(0, 'h00, 32'h4);
    wrReg(4, 'h00, 32'h4);
    inject(2, 4'b0001, 3'd0, 2'd0, 32'h0000_0100);
    chkIrq(1'b0, "R10 fault in disabled context");
    inject(0, 4'b0001, 3'd0, 2'd0, 32'h0000_0200);
    inject(4, 4'b0100, 3'd0, 2'd3, 32'h0000_0300);
    chkIrq(1'b1, "R10 two sources");
    wrReg(0, 'h20, 32'h0);
    chkIrq(1'b1, "R10 one source left");
    wrReg(4, 'h20, 32'h0);
    chkIrq(1'b0, "R10 no source left");

    // R9 zero-flag fault ignored, fresh capture after clear
    inject(3, 4'b0000, 3'd7, 2'd3, 32'hFFFF_FFF0);
    rdReg(3, 'h20, 32'h0, "R9 all-zero flags ignored");
    inject(3, 4'b0010, 3'd0, 2'd0, 32'h0000_0040);
    rdReg(3, 'h20, 32'h0000_0002, "R6 new capture after clear");
    rdReg(3, 'h24, 32'h0000_0040, "R6 new address");

    // R11 idle read data
    @(negedge clk);
    @(negedge clk);
    check(hostRdData, 32'h0, "R11 read data idle");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule